// File: doc/BRIEF.md
# Interframe Gap Enforcer

This block sits between a per-channel transaction scheduler and the bus frame transmitter of one channel. It holds back each new frame until the bus has been idle for a minimum number of bit times. The count starts when the transmitter reports that the closing signal-to-idle transition has begun. It stops when the next idle-to-signal transition would begin. A bit-time tick input paces the block, and a 2-bit gap code chooses one of four minimum gaps. The scheduler raises `start_req` and holds it. The block answers with a one-cycle `frame_start`, and that pulse always falls on a tick.

A channel control write does two things. It aborts a frame in progress, or cancels a gap that is being counted, and after it the next frame may start at once. Its gap code is not used straight away: it is staged, and it becomes the active code when the next frame is launched. The active code then governs the idle time that follows that frame.

The controller has three states. `ST_READY` means the gap is satisfied. `ST_BUSY` means a frame is on the bus. `ST_GAP` means idle time is being counted. The transitions are:
- launch: `ST_READY` to `ST_BUSY`, and `ST_GAP` to `ST_BUSY` on the tick that completes the gap.
- end: `ST_BUSY` to `ST_GAP`.
- abort: `ST_BUSY` to `ST_READY`.
- cancel: `ST_GAP` to `ST_READY`, on a control write.
- release: `ST_GAP` to `ST_READY`, when the gap completes with no request pending.

Top module: `frame_gap_guard`

## Requirements
- R1: After reset, `busy` is 0, `gap_code` is 00 and the gap counts as satisfied. A request present at that point launches on the first `bit_tick`.
- R2: `frame_start` is a one-cycle pulse. It occurs only in a cycle where `bit_tick` and `start_req` are both 1, `busy` is 0, no control write is present and the gap is satisfied.
- R3: `busy` rises in the cycle after `frame_start`. It stays 1 until a cycle in which `frame_end` is sampled, and it is 0 from the cycle after that.
- R4: The minimum gap, counted in ticks strictly after the `frame_end` cycle up to and including the launch tick, is set by the active code: 00 gives 4, 01 gives 5, 10 gives 6 and 11 gives 7.
- R5: A request held through a gap launches on exactly the tick that completes the gap.
- R6: A control write while `busy` is 1 raises `abort` in that same cycle. `busy` is 0 from the next cycle, and the next request launches on its first tick.
- R7: A control write while a gap is being counted cancels the gap with no `abort` pulse. The next request launches on its first tick.
- R8: `gap_code` shows the active code. A written code does not appear there until the cycle after the next `frame_start`, and it then governs the gap that follows that frame.
- R9: `frame_end` has no effect while `busy` is 0. When a control write and `frame_end` arrive in the same busy cycle, the write wins: `abort` fires and no gap is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bus bit time |
| start_req | input | 1 | Scheduler request, held until granted |
| frame_start | output | 1 | Grant pulse telling the transmitter to begin a frame |
| frame_end | input | 1 | Transmitter pulse: closing signal-to-idle transition begins |
| ctrl_wr | input | 1 | Channel control write strobe |
| ctrl_gap_sel | input | CODE_W | Gap code carried by the control write |
| abort | output | 1 | Pulse telling the transmitter to drop the current frame |
| busy | output | 1 | A frame is on the bus |
| gap_code | output | CODE_W | Gap code active for the current or last frame |

## Verification
The bound checker checks several rules on every cycle:
- a launch happens only on a tick, with a request present and the bus idle;
- `busy` follows a launch, and it falls after an end or an abort;
- an abort comes only from a control write on a busy bus;
- the active code changes only at a launch;
- no launch comes earlier than the gap needed by the code in force, tracked by an independent tick counter.

Only the bench scenarios can show the exact timing:
- a held request launches on the very tick that completes the gap, for every code;
- a write cancels a gap with no abort pulse, and a write wins over a same-cycle end;
- a staged code reaches the gap length only after the next frame;
- all of this holds under tick spacings of one and three cycles.

// File: rtl/fgg_pkg.sv
package fgg_pkg;

    // Controller states of the gap enforcer
    typedef enum logic [1:0] {
        ST_READY = 2'd0,   // gap satisfied, waiting for a request
        ST_BUSY  = 2'd1,   // frame on the bus
        ST_GAP   = 2'd2    // idle time being counted
    } fgg_state_t;

endpackage

// File: rtl/fgg_gap_counter.sv
module fgg_gap_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] need,
    output logic             last_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign last_tick = run && tick && (cnt_inc >= {1'b0, need});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && !last_tick) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/fgg_settings_shadow.sv
module fgg_settings_shadow #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic              apply,
    output logic [CODE_W-1:0] active_code
);

    logic [CODE_W-1:0] staged_q;
    logic [CODE_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= '0;
        end else if (load) begin
            staged_q <= load_code;
        end
    end

    // A launch and a write never share a cycle, so apply sees a settled stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (apply) begin
            active_q <= staged_q;
        end
    end

    assign active_code = active_q;

endmodule

// File: rtl/frame_gap_guard.sv
module frame_gap_guard
    import fgg_pkg::*;
#(
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned BASE_GAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              start_req,
    output logic              frame_start,
    input  logic              frame_end,
    input  logic              ctrl_wr,
    input  logic [CODE_W-1:0] ctrl_gap_sel,
    output logic              abort,
    output logic              busy,
    output logic [CODE_W-1:0] gap_code
);

    localparam int unsigned NEED_MAX = BASE_GAP + (1 << CODE_W) - 1;
    localparam int unsigned CNT_W    = $clog2(NEED_MAX + 1);

    fgg_state_t        state_q, state_d;
    logic              do_launch, do_kill;
    logic              gap_last;
    logic [CNT_W-1:0]  need;
    logic [CODE_W-1:0] active_code;

    assign need = CNT_W'(BASE_GAP) + CNT_W'(active_code);

    fgg_gap_counter #(
        .CNT_W (CNT_W)
    ) gap_cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_GAP),
        .tick      (bit_tick),
        .need      (need),
        .last_tick (gap_last)
    );

    fgg_settings_shadow #(
        .CODE_W (CODE_W)
    ) shadow_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ctrl_wr),
        .load_code   (ctrl_gap_sel),
        .apply       (do_launch),
        .active_code (active_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: launch, end, abort, cancel, release
    always_comb begin
        state_d   = state_q;
        do_launch = 1'b0;
        do_kill   = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (!ctrl_wr && bit_tick && start_req) begin
                    state_d   = ST_BUSY;
                    do_launch = 1'b1;
                end
            end
            ST_BUSY: begin
                if (ctrl_wr) begin
                    state_d = ST_READY;
                    do_kill = 1'b1;
                end else if (frame_end) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (ctrl_wr) begin
                    state_d = ST_READY;
                end else if (gap_last) begin
                    if (start_req) begin
                        state_d   = ST_BUSY;
                        do_launch = 1'b1;
                    end else begin
                        state_d = ST_READY;
                    end
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        frame_start = do_launch;
        abort       = do_kill;
        busy        = (state_q == ST_BUSY);
        gap_code    = active_code;
    end

endmodule

// File: rtl/fgg_checker.sv
module fgg_checker #(
    parameter int unsigned CODE_W   = 2,
    parameter int unsigned BASE_GAP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              start_req,
    input logic              frame_start,
    input logic              frame_end,
    input logic              ctrl_wr,
    input logic              abort,
    input logic              busy,
    input logic [CODE_W-1:0] gap_code
);

    localparam int unsigned NEED_MAX = BASE_GAP + (1 << CODE_W) - 1;
    localparam int unsigned SEEN_W   = $clog2(NEED_MAX + 1) + 1;
    localparam logic [SEEN_W-1:0] SEEN_SAT = '1;

    logic [SEEN_W-1:0] seen_q;
    logic [SEEN_W:0]   seen_plus;
    logic [SEEN_W:0]   need_w;

    // Idle ticks since the last closing transition; saturated means no constraint
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= SEEN_SAT;
        end else if (ctrl_wr) begin
            seen_q <= SEEN_SAT;
        end else if (busy && frame_end) begin
            seen_q <= '0;
        end else if (!busy && bit_tick && seen_q != SEEN_SAT) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    assign seen_plus = {1'b0, seen_q} + 1'b1;
    assign need_w    = (SEEN_W + 1)'(BASE_GAP) + (SEEN_W + 1)'(gap_code);

    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_tick && start_req && !busy && !ctrl_wr));

    p_busy_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> busy);

    p_busy_drops_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_end) |=> !busy);

    p_gap_minimum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (seen_q == SEEN_SAT || seen_plus >= need_w));

    p_abort_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (ctrl_wr && busy));

    p_abort_clears_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

    p_code_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(gap_code));

endmodule

bind frame_gap_guard fgg_checker #(
    .CODE_W   (CODE_W),
    .BASE_GAP (BASE_GAP)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .start_req   (start_req),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .ctrl_wr     (ctrl_wr),
    .abort       (abort),
    .busy        (busy),
    .gap_code    (gap_code)
);

// File: tb/frame_gap_guard_tb_top.sv
`timescale 1ns/1ps
module frame_gap_guard_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       start_req = 1'b0;
    logic       frame_end = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [1:0] ctrl_gap_sel = 2'b00;
    logic       frame_start, abort, busy;
    logic [1:0] gap_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // stimulus controls
    int   tp = 3;
    int   div = 0;
    bit   req = 0;
    bit   wr_pend = 0;
    bit   fend_pend = 0;
    logic [1:0] wr_code = 2'b00;

    // reference model
    int m_busy = 0;
    int m_left = 0;
    int m_active = 0;
    int m_staged = 0;

    // observations
    int tcount = 0;
    int last_gap = 0;
    int seen_start = 0;
    int seen_abort = 0;

    always #2.5 clk = ~clk;

    frame_gap_guard dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .start_req    (start_req),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .ctrl_wr      (ctrl_wr),
        .ctrl_gap_sel (ctrl_gap_sel),
        .abort        (abort),
        .busy         (busy),
        .gap_code     (gap_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        bit e_start;
        bit e_abort;
        @(negedge clk);
        bit_tick     = (div == 0);
        div          = (div + 1) % tp;
        ctrl_wr      = wr_pend;
        ctrl_gap_sel = wr_code;
        frame_end    = fend_pend;
        start_req    = req;
        wr_pend      = 0;
        fend_pend    = 0;
        #1;
        e_start = !ctrl_wr && m_busy == 0 && bit_tick && start_req && m_left <= 1;
        e_abort = ctrl_wr && m_busy == 1;
        chk(frame_start == e_start, "R2 frame_start", int'(frame_start), int'(e_start));
        chk(abort == e_abort, "R6 abort", int'(abort), int'(e_abort));
        chk(int'(busy) == m_busy, "R3 busy", int'(busy), m_busy);
        chk(int'(gap_code) == m_active, "R8 gap_code", int'(gap_code), m_active);
        if (bit_tick) tcount++;
        if (frame_end && m_busy == 1) tcount = 0;
        if (frame_start) begin
            last_gap = tcount;
            seen_start++;
            req = 0;
        end
        if (abort) seen_abort++;
        @(posedge clk);
        if (ctrl_wr) begin
            m_staged = int'(ctrl_gap_sel);
            m_busy   = 0;
            m_left   = 0;
        end else if (m_busy == 1 && frame_end) begin
            m_busy = 0;
            m_left = 4 + m_active;
        end else if (e_start) begin
            m_busy   = 1;
            m_active = m_staged;
            m_left   = 0;
        end else if (m_busy == 0 && bit_tick && m_left > 0) begin
            m_left--;
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_to_start(input string tag);
        int s0;
        s0 = seen_start;
        for (int i = 0; i < 200 && seen_start == s0; i++) step();
        chk(seen_start != s0, tag, seen_start - s0, 1);
    endtask

    task automatic end_frame();
        steps(3);
        fend_pend = 1;
        step();
    endtask

    task automatic gap_trial(input int code);
        int prev;
        steps(30);
        prev    = int'(gap_code);
        wr_pend = 1;
        wr_code = 2'(code);
        step();
        chk(int'(gap_code) == prev, "R8 code staged not active", int'(gap_code), prev);
        req = 1;
        run_to_start("R2 launch");
        step();
        chk(int'(gap_code) == code, "R8 code active after launch", int'(gap_code), code);
        steps(3);
        fend_pend = 1;
        req = 1;
        step();
        run_to_start("R5 held request launch");
        chk(last_gap == 4 + code, "R4/R5 gap length", last_gap, 4 + code);
        end_frame();
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(gap_code == 2'b00, "R1 reset gap_code", int'(gap_code), 0);
        chk(frame_start == 1'b0, "R1 reset frame_start", int'(frame_start), 0);
        @(negedge clk);
        rst_n = 1'b1;
        div = 0;
        req = 1;
        tcount = 0;
        run_to_start("R1 first launch");
        chk(last_gap == 1, "R1 first launch on first tick", last_gap, 1);
        end_frame();

        for (int c = 0; c < 4; c++) gap_trial(c);

        // tick every cycle
        tp = 1;
        div = 0;
        gap_trial(2);
        tp = 3;
        div = 0;

        // abort while busy
        steps(30);
        req = 1;
        run_to_start("R6 launch");
        steps(2);
        a0 = seen_abort;
        wr_pend = 1;
        wr_code = 2'b01;
        step();
        chk(seen_abort == a0 + 1, "R6 abort pulse", seen_abort - a0, 1);
        step();
        chk(busy == 1'b0, "R6 busy cleared", int'(busy), 0);
        req = 1;
        tcount = 0;
        run_to_start("R6 relaunch");
        chk(last_gap == 1, "R6 gap satisfied after abort", last_gap, 1);

        // write during gap counting (active code 01, gap 5)
        end_frame();
        steps(4);
        a0 = seen_abort;
        wr_pend = 1;
        wr_code = 2'b01;
        step();
        chk(seen_abort == a0, "R7 no abort in gap", seen_abort - a0, 0);
        req = 1;
        tcount = 0;
        run_to_start("R7 relaunch");
        chk(last_gap == 1, "R7 gap cancelled", last_gap, 1);
        end_frame();

        // frame_end while idle is ignored
        steps(30);
        fend_pend = 1;
        step();
        chk(busy == 1'b0, "R9 idle end ignored busy", int'(busy), 0);
        req = 1;
        tcount = 0;
        run_to_start("R9 launch");
        chk(last_gap == 1, "R9 idle end no gap", last_gap, 1);

        // write and end in the same busy cycle
        steps(2);
        a0 = seen_abort;
        fend_pend = 1;
        wr_pend = 1;
        wr_code = 2'b11;
        step();
        chk(seen_abort == a0 + 1, "R9 write wins abort", seen_abort - a0, 1);
        req = 1;
        tcount = 0;
        run_to_start("R9 relaunch");
        chk(last_gap == 1, "R9 write wins no gap", last_gap, 1);
        end_frame();
        steps(10);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule